// File: doc/BRIEF.md
# Code Histogram Analyzer

This block builds a code-density histogram from a stream of converter output codes. Each sample arriving on a valid-qualified code bus, while a run is active, adds one to the counter of the bin whose index equals the code. A run is opened by a start pulse together with a programmed sample count. It closes by itself once that many samples have been taken in. A clear command wipes the whole histogram beforehand. Bins that are too full or too empty compared with their neighbours reveal wide or narrow steps. An empty bin reveals a code the converter never produced.

As the run proceeds, the block records the lowest and highest code accepted. When the run closes it sweeps every bin once and counts the empty bins that lie inside that observed range. It also reports the lowest such empty code. Bins outside the swing of the test signal are therefore not reported. Software or a test sequencer reads the bin counts through a simple address-in, count-out port.

Top module: `code_hist_top`

## Requirements
- R1: There are 2^CODE_W bins (256 by default), one per code value. `rd_count_o` shows the count of bin `rd_addr_i` combinationally. After reset every bin reads 0 and `busy_o`, `running_o` and `done_o` are low.
- R2: In the running state, each cycle with `smp_valid_i` high adds exactly one to the bin addressed by `smp_code_i`.
- R3: A bin that holds the all-ones value (2^COUNT_W-1) keeps that value when it receives further samples. It does not wrap.
- R4: A start pulse taken while idle or done captures `target_i` and enters the running state. Once `target_i` samples have been accepted, the run stops at that clock edge, and later samples have no effect on any bin.
- R5: Samples offered while not running, and cycles with `smp_valid_i` low, change no bin and no range output.
- R6: A clear pulse taken while idle or done zeroes one bin per clock. `busy_o` is high for exactly 2^CODE_W cycles during the sweep. The sweep also resets the range outputs and the missing-code results. If clear and start arrive together, clear wins.
- R7: `seen_o` goes high after the first accepted sample. `min_code_o` and `max_code_o` give the lowest and highest code accepted since the last clear, and min never exceeds max.
- R8: When a run closes, `busy_o` stays high for 2^CODE_W scan cycles, and then `done_o` rises. `miss_count_o` is the number of zero bins whose code lies within [min, max]. `miss_first_o` is the lowest such code, and `miss_any_o` is high when at least one exists. With no sample seen, nothing is flagged.
- R9: At most one of `busy_o`, `running_o` and `done_o` is high at any time.
- R10: A start with `target_i` equal to 0 accepts no sample and goes straight to the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Clear histogram command (pulse) |
| start_i | input | 1 | Start run command (pulse) |
| target_i | input | TGT_W | Number of samples per run |
| smp_valid_i | input | 1 | Sample qualifier |
| smp_code_i | input | CODE_W | Converter output code |
| rd_addr_i | input | CODE_W | Bin read address |
| rd_count_o | output | COUNT_W | Count of the addressed bin |
| busy_o | output | 1 | Clear sweep or final scan in progress |
| running_o | output | 1 | Run accepting samples |
| done_o | output | 1 | Run and scan finished |
| seen_o | output | 1 | At least one sample accepted since clear |
| min_code_o | output | CODE_W | Lowest accepted code |
| max_code_o | output | CODE_W | Highest accepted code |
| miss_count_o | output | CODE_W+1 | Empty bins within the observed range |
| miss_first_o | output | CODE_W | Lowest empty code within the range |
| miss_any_o | output | 1 | At least one missing code |

## Verification
The bench uses a 16-bin, 4-bit-count configuration so that every bin can be read back after each run. A full ramp over all codes shows that each bin fills once, with no misses and the full range. A sparse pattern with holes, fed with idle gaps and garbage codes in between, separates in-range empty bins from out-of-range ones. A long run on a single code shows saturation. Further runs check overrun after the target, samples offered while not running, accumulation without a clear, and a zero target, each separating a bin or range change from a correctly ignored input.

// File: rtl/chist_pkg.sv
package chist_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WIPE,
      ST_RUN,
      ST_SCAN,
      ST_DONE
   } chist_state_e;
endpackage

// File: rtl/chist_bin_array.sv
module chist_bin_array #(
   parameter int CODE_W  = 8,
   parameter int COUNT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wipe_i,
   input  logic [CODE_W-1:0]  wipe_addr_i,
   input  logic               inc_i,
   input  logic [CODE_W-1:0]  inc_addr_i,
   input  logic [CODE_W-1:0]  rd_addr_i,
   output logic [COUNT_W-1:0] rd_count_o,
   input  logic [CODE_W-1:0]  scan_addr_i,
   output logic [COUNT_W-1:0] scan_count_o
);
   localparam int NBINS = 1 << CODE_W;
   localparam logic [COUNT_W-1:0] CNT_MAX = '1;

   logic [COUNT_W-1:0] cnt_q [NBINS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < NBINS; b++) cnt_q[b] <= '0;
      end else begin
         for (int b = 0; b < NBINS; b++) begin
            if (wipe_i && wipe_addr_i == CODE_W'(b))
               cnt_q[b] <= '0;
            else if (inc_i && inc_addr_i == CODE_W'(b) && cnt_q[b] != CNT_MAX)
               cnt_q[b] <= cnt_q[b] + 1'b1;
         end
      end
   end

   assign rd_count_o   = cnt_q[rd_addr_i];
   assign scan_count_o = cnt_q[scan_addr_i];

   // R3
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !wipe_i && cnt_q[inc_addr_i] == CNT_MAX)
      |=> cnt_q[$past(inc_addr_i)] == CNT_MAX);

   // R2
   bin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !wipe_i && cnt_q[inc_addr_i] != CNT_MAX)
      |=> cnt_q[$past(inc_addr_i)] == $past(cnt_q[inc_addr_i]) + 1'b1);
endmodule

// File: rtl/chist_range.sv
module chist_range #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reset_i,
   input  logic              upd_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              seen_o,
   output logic [CODE_W-1:0] lo_o,
   output logic [CODE_W-1:0] hi_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_o <= 1'b0;
         lo_o   <= '0;
         hi_o   <= '0;
      end else if (reset_i) begin
         seen_o <= 1'b0;
         lo_o   <= '0;
         hi_o   <= '0;
      end else if (upd_i) begin
         seen_o <= 1'b1;
         if (!seen_o || code_i < lo_o) lo_o <= code_i;
         if (!seen_o || code_i > hi_o) hi_o <= code_i;
      end
   end

   // R7
   range_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen_o |-> lo_o <= hi_o);
endmodule

// File: rtl/chist_gap_scan.sv
module chist_gap_scan #(
   parameter int CODE_W  = 8,
   parameter int COUNT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reset_i,
   input  logic               step_i,
   input  logic [CODE_W-1:0]  addr_i,
   input  logic [COUNT_W-1:0] count_i,
   input  logic               seen_i,
   input  logic [CODE_W-1:0]  lo_i,
   input  logic [CODE_W-1:0]  hi_i,
   output logic [CODE_W:0]    miss_count_o,
   output logic [CODE_W-1:0]  miss_first_o,
   output logic               miss_any_o
);
   localparam int NBINS = 1 << CODE_W;

   logic hole;
   assign hole = step_i && seen_i && addr_i >= lo_i && addr_i <= hi_i && count_i == '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         miss_count_o <= '0;
         miss_first_o <= '0;
         miss_any_o   <= 1'b0;
      end else if (reset_i) begin
         miss_count_o <= '0;
         miss_first_o <= '0;
         miss_any_o   <= 1'b0;
      end else if (hole) begin
         miss_count_o <= miss_count_o + 1'b1;
         miss_any_o   <= 1'b1;
         if (!miss_any_o) miss_first_o <= addr_i;
      end
   end

   // R8
   miss_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      miss_count_o <= (CODE_W+1)'(NBINS));

   // R8
   first_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(miss_any_o) |-> (miss_first_o >= lo_i && miss_first_o <= hi_i));
endmodule

// File: rtl/code_hist_top.sv
module code_hist_top
   import chist_pkg::*;
#(
   parameter int CODE_W  = 8,
   parameter int COUNT_W = 16,
   parameter int TGT_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear_i,
   input  logic               start_i,
   input  logic [TGT_W-1:0]   target_i,
   input  logic               smp_valid_i,
   input  logic [CODE_W-1:0]  smp_code_i,
   input  logic [CODE_W-1:0]  rd_addr_i,
   output logic [COUNT_W-1:0] rd_count_o,
   output logic               busy_o,
   output logic               running_o,
   output logic               done_o,
   output logic               seen_o,
   output logic [CODE_W-1:0]  min_code_o,
   output logic [CODE_W-1:0]  max_code_o,
   output logic [CODE_W:0]    miss_count_o,
   output logic [CODE_W-1:0]  miss_first_o,
   output logic               miss_any_o
);
   localparam logic [CODE_W-1:0] LAST_IDX = '1;

   if (CODE_W < 1 || CODE_W > 10) begin : g_bad_code_w
      $error("code_hist_top: CODE_W must be within 1..10");
   end
   if (COUNT_W < 2) begin : g_bad_count_w
      $error("code_hist_top: COUNT_W must be at least 2");
   end
   if (TGT_W < 1) begin : g_bad_tgt_w
      $error("code_hist_top: TGT_W must be at least 1");
   end

   chist_state_e       state_q;
   logic [CODE_W-1:0]  idx_q;
   logic [TGT_W-1:0]   taken_q;
   logic [TGT_W-1:0]   target_q;
   logic               cmd_ok, clear_go, start_go, accept;
   logic [COUNT_W-1:0] scan_count;

   assign cmd_ok   = (state_q == ST_IDLE) || (state_q == ST_DONE);
   assign clear_go = cmd_ok && clear_i;
   assign start_go = cmd_ok && start_i && !clear_i;
   assign accept   = (state_q == ST_RUN) && smp_valid_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         idx_q    <= '0;
         taken_q  <= '0;
         target_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE, ST_DONE: begin
               idx_q <= '0;
               if (clear_go) begin
                  state_q <= ST_WIPE;
               end else if (start_go) begin
                  target_q <= target_i;
                  taken_q  <= '0;
                  state_q  <= (target_i == '0) ? ST_SCAN : ST_RUN;
               end
            end
            ST_WIPE: begin
               idx_q <= idx_q + 1'b1;
               if (idx_q == LAST_IDX) state_q <= ST_IDLE;
            end
            ST_RUN: begin
               if (smp_valid_i) begin
                  taken_q <= taken_q + 1'b1;
                  if (taken_q + 1'b1 == target_q) begin
                     state_q <= ST_SCAN;
                     idx_q   <= '0;
                  end
               end
            end
            ST_SCAN: begin
               idx_q <= idx_q + 1'b1;
               if (idx_q == LAST_IDX) state_q <= ST_DONE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   chist_bin_array #(.CODE_W(CODE_W), .COUNT_W(COUNT_W)) u_bins (
      .clk          (clk),
      .rst_n        (rst_n),
      .wipe_i       (state_q == ST_WIPE),
      .wipe_addr_i  (idx_q),
      .inc_i        (accept),
      .inc_addr_i   (smp_code_i),
      .rd_addr_i    (rd_addr_i),
      .rd_count_o   (rd_count_o),
      .scan_addr_i  (idx_q),
      .scan_count_o (scan_count)
   );

   chist_range #(.CODE_W(CODE_W)) u_range (
      .clk     (clk),
      .rst_n   (rst_n),
      .reset_i (clear_go),
      .upd_i   (accept),
      .code_i  (smp_code_i),
      .seen_o  (seen_o),
      .lo_o    (min_code_o),
      .hi_o    (max_code_o)
   );

   chist_gap_scan #(.CODE_W(CODE_W), .COUNT_W(COUNT_W)) u_scan (
      .clk          (clk),
      .rst_n        (rst_n),
      .reset_i      (clear_go || start_go),
      .step_i       (state_q == ST_SCAN),
      .addr_i       (idx_q),
      .count_i      (scan_count),
      .seen_i       (seen_o),
      .lo_i         (min_code_o),
      .hi_i         (max_code_o),
      .miss_count_o (miss_count_o),
      .miss_first_o (miss_first_o),
      .miss_any_o   (miss_any_o)
   );

   assign busy_o    = (state_q == ST_WIPE) || (state_q == ST_SCAN);
   assign running_o = (state_q == ST_RUN);
   assign done_o    = (state_q == ST_DONE);

   // R9
   status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({busy_o, running_o, done_o}));

   // R4
   run_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      running_o |-> taken_q < target_q);

   // R8
   done_after_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(state_q) == ST_SCAN);

   // R5
   idle_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DONE && !clear_i) |=> $stable(min_code_o) && $stable(max_code_o));
endmodule

// File: tb/tb_code_hist_top.sv
module tb_code_hist_top;
   localparam int CW = 4;
   localparam int KW = 4;
   localparam int TW = 8;
   localparam int NB = 1 << CW;
   localparam int KMAX = (1 << KW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clear_i = 1'b0, start_i = 1'b0, smp_valid_i = 1'b0;
   logic [TW-1:0] target_i = '0;
   logic [CW-1:0] smp_code_i = '0, rd_addr_i = '0;
   logic [KW-1:0] rd_count_o;
   logic busy_o, running_o, done_o, seen_o, miss_any_o;
   logic [CW-1:0] min_code_o, max_code_o, miss_first_o;
   logic [CW:0] miss_count_o;

   int checks = 0, errors = 0;
   int exp_bin [NB];
   int exp_seen = 0, exp_lo = 0, exp_hi = 0;
   int codes [64];

   always #5 clk = ~clk;

   code_hist_top #(.CODE_W(CW), .COUNT_W(KW), .TGT_W(TW)) dut (
      .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .start_i(start_i),
      .target_i(target_i), .smp_valid_i(smp_valid_i), .smp_code_i(smp_code_i),
      .rd_addr_i(rd_addr_i), .rd_count_o(rd_count_o), .busy_o(busy_o),
      .running_o(running_o), .done_o(done_o), .seen_o(seen_o),
      .min_code_o(min_code_o), .max_code_o(max_code_o),
      .miss_count_o(miss_count_o), .miss_first_o(miss_first_o),
      .miss_any_o(miss_any_o)
   );

   task automatic chk(input string req, input int act, input int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic check_bins(input string req);
      for (int b = 0; b < NB; b++) begin
         rd_addr_i = CW'(b);
         #1;
         chk(req, int'(rd_count_o), exp_bin[b]);
      end
   endtask

   task automatic check_results(input string req);
      int mc = 0, mf = 0;
      if (exp_seen != 0)
         for (int c = exp_lo; c <= exp_hi; c++)
            if (exp_bin[c] == 0) begin
               if (mc == 0) mf = c;
               mc++;
            end
      chk({req, " R7 seen"}, int'(seen_o), exp_seen);
      if (exp_seen != 0) begin
         chk({req, " R7 min"}, int'(min_code_o), exp_lo);
         chk({req, " R7 max"}, int'(max_code_o), exp_hi);
      end
      chk({req, " R8 miss count"}, int'(miss_count_o), mc);
      chk({req, " R8 miss any"}, int'(miss_any_o), (mc != 0) ? 1 : 0);
      if (mc != 0) chk({req, " R8 first miss"}, int'(miss_first_o), mf);
      check_bins({req, " R2 bins"});
   endtask

   task automatic do_clear();
      int cnt = 0;
      @(negedge clk);
      clear_i = 1'b1;
      @(negedge clk);
      clear_i = 1'b0;
      while (busy_o && cnt < 100) begin
         cnt++;
         @(negedge clk);
      end
      chk("R6 wipe cycles", cnt, NB);
      chk("R9 idle after wipe", int'({busy_o, running_o, done_o}), 0);
      for (int b = 0; b < NB; b++) exp_bin[b] = 0;
      exp_seen = 0;
   endtask

   task automatic do_run(input int n, input int target, input bit gaps, input string tag);
      int cnt = 0;
      @(negedge clk);
      start_i  = 1'b1;
      target_i = TW'(target);
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < n; i++) begin
         smp_valid_i = 1'b1;
         smp_code_i  = CW'(codes[i]);
         if (i < target) begin
            if (exp_bin[codes[i]] < KMAX) exp_bin[codes[i]]++;
            if (exp_seen == 0 || codes[i] < exp_lo) exp_lo = codes[i];
            if (exp_seen == 0 || codes[i] > exp_hi) exp_hi = codes[i];
            exp_seen = 1;
         end
         @(negedge clk);
         if (gaps) begin
            smp_valid_i = 1'b0;
            smp_code_i  = ~CW'(codes[i]);
            @(negedge clk);
         end
      end
      smp_valid_i = 1'b0;
      while (busy_o && cnt < 100) begin
         cnt++;
         @(negedge clk);
      end
      if (n == target && !gaps) chk({tag, " R8 scan cycles"}, cnt, NB);
      chk({tag, " R8 done"}, int'(done_o), 1);
      chk({tag, " R9 status"}, int'({busy_o, running_o}), 0);
      check_results(tag);
   endtask

   initial begin
      #1_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int b = 0; b < NB; b++) exp_bin[b] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 reset status", int'({busy_o, running_o, done_o}), 0);
      chk("R1 reset miss", int'(miss_count_o), 0);
      check_bins("R1 reset bins");

      // R6 clear sweep
      do_clear();

      // Ramp: every code once (R1, R2)
      for (int i = 0; i < NB; i++) codes[i] = i;
      do_run(NB, NB, 1'b0, "ramp R1");

      // Sparse with holes and idle gaps (R5, R8)
      do_clear();
      check_bins("R6 after clear");
      codes[0] = 3; codes[1] = 4; codes[2] = 6; codes[3] = 6; codes[4] = 9;
      codes[5] = 3; codes[6] = 4; codes[7] = 9; codes[8] = 6; codes[9] = 9;
      do_run(10, 10, 1'b1, "holes R5");

      // Saturation on one code (R3)
      do_clear();
      for (int i = 0; i < 20; i++) codes[i] = 7;
      do_run(20, 20, 1'b0, "sat R3");

      // Samples while done are ignored (R5)
      @(negedge clk);
      for (int i = 0; i < 5; i++) begin
         smp_valid_i = 1'b1;
         smp_code_i  = CW'(2 + i);
         @(negedge clk);
      end
      smp_valid_i = 1'b0;
      check_bins("R5 no run bins");
      chk("R5 no run min", int'(min_code_o), exp_lo);
      chk("R5 no run max", int'(max_code_o), exp_hi);

      // Accumulate without clear (R2, R7)
      codes[0] = 0; codes[1] = 15;
      do_run(2, 2, 1'b0, "accum R2");

      // Overrun beyond target (R4)
      do_clear();
      codes[0] = 5; codes[1] = 5; codes[2] = 2; codes[3] = 2;
      codes[4] = 9; codes[5] = 9; codes[6] = 9; codes[7] = 9;
      do_run(8, 4, 1'b0, "overrun R4");

      // Zero target (R10)
      do_clear();
      codes[0] = 1; codes[1] = 1; codes[2] = 1;
      do_run(3, 0, 1'b0, "zero R10");

      // Clear and start together: clear wins (R6)
      @(negedge clk);
      clear_i = 1'b1;
      start_i = 1'b1;
      target_i = TW'(3);
      @(negedge clk);
      clear_i = 1'b0;
      start_i = 1'b0;
      chk("R6 clear priority busy", int'(busy_o), 1);
      chk("R6 clear priority run", int'(running_o), 0);
      repeat (NB + 2) @(negedge clk);
      chk("R6 clear priority idle", int'({busy_o, running_o, done_o}), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule